// File: doc/BRIEF.md
# Watchdog and Alarm Countdown Controller

This block is a countdown timer with a register interface. It has one down-counter whose width is set by a parameter. The counter runs in one of two modes. In the repeating alarm mode it counts whole-second ticks, raises a sticky alarm flag each time it reaches zero, and restarts from its stored reload value. In the one-shot watchdog mode it counts a fast 4096 Hz tick. When it reaches zero it raises the flag, stops, and sends a timed active-low pulse to either the reset pin or the interrupt pin.

The host reaches the block through a plain register bus with write strobe, read strobe, address and byte-wide data. A watchdog is kept alive by touching any of the reload byte registers, because every such read or write reloads and restarts the count. The interrupt pin also reports the sticky alarm flag when the interrupt enable bit and the external interrupt-control input are both set.

Top module: `wdalm_ctrl`

## Requirements
- R1: After reset, control (address 3) reads 0x06, the alarm flag is 0, and both `int_n` and `reset_n` are high.
- R2: With enable (control bit 6) at 0, no tick changes anything. The reload bytes read back exactly what was written: address 0 is the low byte, address 1 the middle byte, address 2 the high byte. Control bits 7, 4, 2 and 1 are storage only.
- R3: When enable is 1 and mode (control bit 5) is 0, the count decrements on each `tick_sec` and ignores `tick_fast`. When it reaches zero it sets the flag and reloads from the reload bytes, so the next flag follows after another full period.
- R4: When mode is 1, the count decrements on each `tick_fast`. When it reaches zero it sets the flag and stops; later ticks raise no new flag.
- R5: A read or write of any reload byte reloads the count from the reload bytes and restarts it. Enabling the counter (bit 6 going from 0 to 1) also loads it.
- R6: A watchdog expiry drives a low pulse lasting PULSE_TICKS `tick_fast` ticks. The pulse goes on `reset_n` when steering (control bit 3) is 0 and on `int_n` when it is 1. A new expiry during a pulse does not restart it.
- R7: The alarm flag pulls `int_n` low only while interrupt enable (control bit 0) is 1 and `int_ctl` is 1.
- R8: Clearing interrupt enable during a pulse on `int_n` does not shorten the pulse.
- R9: The flag reads as bit 0 of status (address 4). It stays set until the host writes a 0 there. Writing a 1 has no effect.
- R10: A reload value of zero leaves the counter idle, with no flag and no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | ADDR_W | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, registered, valid the cycle after `rd_en` |
| tick_sec | input | 1 | One-cycle 1 Hz tick |
| tick_fast | input | 1 | One-cycle 4096 Hz tick |
| int_ctl | input | 1 | Interrupt-control input that gates the flag onto `int_n` |
| alarm_flag | output | 1 | Sticky alarm flag |
| int_n | output | 1 | Active-low interrupt, registered |
| reset_n | output | 1 | Active-low reset pulse, registered |

## Verification
The bench builds the block with the default 24-bit counter and sets PULSE_TICKS to 8. With that short pulse, the start, the full length and the end of a watchdog pulse can each be seen within a few dozen cycles, on both steering targets. Because the bench drives the ticks itself, short reload values reach the alarm rollover, the watchdog stop, the keep-alive reload and the zero-reload corner quickly. The 24-bit path is still covered by writing and reading back all three reload bytes.

// File: rtl/wdalm_pkg.sv
package wdalm_pkg;
  localparam int CB_OSC_OFF = 7;
  localparam int CB_ENABLE  = 6;
  localparam int CB_MODE    = 5;
  localparam int CB_BBSQ    = 4;
  localparam int CB_STEER   = 3;
  localparam int CB_RATE2   = 2;
  localparam int CB_RATE1   = 1;
  localparam int CB_AIE     = 0;
  localparam logic [7:0] CTRL_RESET = 8'h06;
endpackage

// File: rtl/wdalm_regs.sv
module wdalm_regs #(
  parameter int CNT_W  = 24,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  input  logic              flag_set,
  output logic [7:0]        rdata,
  output logic [7:0]        ctrl,
  output logic [CNT_W-1:0]  reload,
  output logic              flag,
  output logic              load_req
);
  localparam int NB = CNT_W / 8;
  localparam logic [ADDR_W-1:0] A_CTL = ADDR_W'(NB);
  localparam logic [ADDR_W-1:0] A_STS = ADDR_W'(NB + 1);

  logic [7:0] rel_q [NB];
  logic       cnt_hit;

  assign cnt_hit = (addr < A_CTL);

  for (genvar b = 0; b < NB; b++) begin : g_byte
    always_ff @(posedge clk) begin
      if (rst) rel_q[b] <= '0;
      else if (wr_en && addr == ADDR_W'(b)) rel_q[b] <= wdata;
    end
    assign reload[b*8 +: 8] = rel_q[b];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl     <= wdalm_pkg::CTRL_RESET;
      flag     <= 1'b0;
      load_req <= 1'b0;
      rdata    <= '0;
    end else begin
      load_req <= (wr_en || rd_en) && cnt_hit;
      if (wr_en && addr == A_CTL) ctrl <= wdata;
      if (flag_set) flag <= 1'b1;
      else if (wr_en && addr == A_STS && !wdata[0]) flag <= 1'b0;
      if (rd_en) begin
        if (cnt_hit)            rdata <= rel_q[addr];
        else if (addr == A_CTL) rdata <= ctrl;
        else if (addr == A_STS) rdata <= {7'b0, flag};
        else                    rdata <= '0;
      end
    end
  end
endmodule

// File: rtl/wdalm_counter.sv
module wdalm_counter #(
  parameter int CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             enable,
  input  logic             mode,
  input  logic             tick_sec,
  input  logic             tick_fast,
  input  logic             load_req,
  input  logic [CNT_W-1:0] reload,
  output logic             running,
  output logic             expire,
  output logic [CNT_W-1:0] count
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic en_prev;
  logic tick;
  logic do_load;

  assign tick    = mode ? tick_fast : tick_sec;
  assign do_load = load_req || !en_prev;
  assign expire  = enable && !do_load && running && tick && (count == ONE);

  always_ff @(posedge clk) begin
    if (rst) begin
      count   <= '0;
      running <= 1'b0;
      en_prev <= 1'b0;
    end else begin
      en_prev <= enable;
      if (!enable) begin
        running <= 1'b0;
      end else if (do_load) begin
        count   <= reload;
        running <= (reload != '0);
      end else if (running && tick) begin
        if (count == ONE) begin
          if (mode) begin
            running <= 1'b0;
            count   <= '0;
          end else begin
            count <= reload;
          end
        end else begin
          count <= count - ONE;
        end
      end
    end
  end
endmodule

// File: rtl/wdalm_pulse.sv
module wdalm_pulse #(
  parameter int PULSE_TICKS = 1024
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic steer,
  input  logic tick_fast,
  output logic active,
  output logic on_int
);
  localparam int PW = $clog2(PULSE_TICKS + 1);
  localparam logic [PW-1:0] LAST = PW'(PULSE_TICKS - 1);

  logic [PW-1:0] pcnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      active <= 1'b0;
      on_int <= 1'b0;
      pcnt   <= '0;
    end else if (start && !active) begin
      active <= 1'b1;
      on_int <= steer;
      pcnt   <= '0;
    end else if (active && tick_fast) begin
      if (pcnt == LAST) active <= 1'b0;
      else              pcnt   <= pcnt + 1'b1;
    end
  end
endmodule

// File: rtl/wdalm_ctrl.sv
module wdalm_ctrl #(
  parameter int CNT_W       = 24,
  parameter int ADDR_W      = 3,
  parameter int PULSE_TICKS = 1024
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  output logic [7:0]        rdata,
  input  logic              tick_sec,
  input  logic              tick_fast,
  input  logic              int_ctl,
  output logic              alarm_flag,
  output logic              int_n,
  output logic              reset_n
);
  import wdalm_pkg::*;

  logic [7:0]       ctrl;
  logic [CNT_W-1:0] reload;
  logic [CNT_W-1:0] count;
  logic             load_req, running, expire;
  logic             pulse_active, pulse_on_int;
  logic             ctl_en, ctl_mode;

  assign ctl_en   = ctrl[CB_ENABLE];
  assign ctl_mode = ctrl[CB_MODE];

  wdalm_regs #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .flag_set(expire), .rdata(rdata), .ctrl(ctrl),
    .reload(reload), .flag(alarm_flag), .load_req(load_req)
  );

  wdalm_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .enable(ctl_en), .mode(ctl_mode),
    .tick_sec(tick_sec), .tick_fast(tick_fast), .load_req(load_req),
    .reload(reload), .running(running), .expire(expire), .count(count)
  );

  wdalm_pulse #(.PULSE_TICKS(PULSE_TICKS)) u_pulse (
    .clk(clk), .rst(rst), .start(expire && ctl_mode),
    .steer(ctrl[CB_STEER]), .tick_fast(tick_fast),
    .active(pulse_active), .on_int(pulse_on_int)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      int_n   <= 1'b1;
      reset_n <= 1'b1;
    end else begin
      int_n   <= !((alarm_flag && ctrl[CB_AIE] && int_ctl) ||
                   (pulse_active && pulse_on_int));
      reset_n <= !(pulse_active && !pulse_on_int);
    end
  end
endmodule

// File: rtl/wdalm_chk.sv
module wdalm_chk #(
  parameter int CNT_W = 24
) (
  input logic             clk,
  input logic             rst,
  input logic             wr_en,
  input logic             alarm_flag,
  input logic             reset_n,
  input logic             enable,
  input logic             mode,
  input logic             running,
  input logic             expire,
  input logic [CNT_W-1:0] count,
  input logic             pulse_active,
  input logic             pulse_on_int
);
  AST_IDLE_WHEN_OFF: assert property (@(posedge clk) disable iff (rst)
    !enable |=> !running); // R2
  AST_ALARM_REPEATS: assert property (@(posedge clk) disable iff (rst)
    (expire && !mode) |=> running); // R3
  AST_WD_HALTS: assert property (@(posedge clk) disable iff (rst)
    (expire && mode) |=> !running); // R4
  AST_RST_PULSE_SRC: assert property (@(posedge clk) disable iff (rst)
    !reset_n |-> $past(pulse_active && !pulse_on_int)); // R6
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
    (alarm_flag && !wr_en) |=> alarm_flag); // R9
  AST_ZERO_NEVER_RUNS: assert property (@(posedge clk) disable iff (rst)
    running |-> (count != '0)); // R10
endmodule

bind wdalm_ctrl wdalm_chk chk_i (
  .clk(clk), .rst(rst), .wr_en(wr_en), .alarm_flag(alarm_flag),
  .reset_n(reset_n), .enable(ctl_en), .mode(ctl_mode), .running(running),
  .expire(expire), .count(count), .pulse_active(pulse_active),
  .pulse_on_int(pulse_on_int)
);

// File: tb/wdalm_ctrl_tb.sv
`timescale 1ns/1ps
module wdalm_ctrl_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0, rd_en = 1'b0;
  logic [2:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       tick_sec = 1'b0, tick_fast = 1'b0, int_ctl = 1'b1;
  logic       alarm_flag, int_n, reset_n;
  int nchk = 0, nfail = 0;

  always #2 clk = ~clk;

  wdalm_ctrl #(.CNT_W(24), .ADDR_W(3), .PULSE_TICKS(8)) dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .tick_sec(tick_sec), .tick_fast(tick_fast),
    .int_ctl(int_ctl), .alarm_flag(alarm_flag), .int_n(int_n), .reset_n(reset_n)
  );

  // {is_write, addr, data, expected read}
  localparam int NV = 12;
  localparam logic [19:0] VEC [NV] = '{
    {1'b0, 3'd3, 8'h00, 8'h06},
    {1'b1, 3'd0, 8'hA5, 8'h00},
    {1'b1, 3'd1, 8'h3C, 8'h00},
    {1'b1, 3'd2, 8'h7E, 8'h00},
    {1'b0, 3'd0, 8'h00, 8'hA5},
    {1'b0, 3'd1, 8'h00, 8'h3C},
    {1'b0, 3'd2, 8'h00, 8'h7E},
    {1'b1, 3'd3, 8'h96, 8'h00},
    {1'b0, 3'd3, 8'h00, 8'h96},
    {1'b1, 3'd3, 8'h06, 8'h00},
    {1'b0, 3'd3, 8'h00, 8'h06},
    {1'b0, 3'd4, 8'h00, 8'h00}
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin @(posedge clk); #1; end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a);
    rd_en = 1'b1; addr = a;
    @(posedge clk); #1;
    rd_en = 1'b0;
  endtask

  task automatic tf(input int n);
    for (int i = 0; i < n; i++) begin
      tick_fast = 1'b1; @(posedge clk); #1; tick_fast = 1'b0;
    end
  endtask

  task automatic ts(input int n);
    for (int i = 0; i < n; i++) begin
      tick_sec = 1'b1; @(posedge clk); #1; tick_sec = 1'b0;
    end
  endtask

  initial begin
    #80000;
    nfail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    idle(3); rst = 1'b0; idle(1);
    chk("R1 flag", {7'b0, alarm_flag}, 8'h00);
    chk("R1 int_n", {7'b0, int_n}, 8'h01);
    chk("R1 reset_n", {7'b0, reset_n}, 8'h01);

    // R1 and R2: register table
    for (int v = 0; v < NV; v++) begin
      if (VEC[v][19]) wr(VEC[v][18:16], VEC[v][15:8]);
      else begin
        rd(VEC[v][18:16]);
        chk("R1/R2 table", rdata, VEC[v][7:0]);
      end
    end

    // R2: disabled, ticks have no effect
    ts(5); tf(5); idle(1);
    chk("R2 no flag when off", {7'b0, alarm_flag}, 8'h00);
    rd(3'd0); chk("R2 storage kept", rdata, 8'hA5);

    // R3 alarm mode, reload 3
    wr(3'd0, 8'd3); wr(3'd1, 8'd0); wr(3'd2, 8'd0);
    wr(3'd3, 8'h41); idle(1);
    tf(5); ts(2); idle(1);
    chk("R3 not yet", {7'b0, alarm_flag}, 8'h00);
    ts(1);
    chk("R3 flag at zero", {7'b0, alarm_flag}, 8'h01);
    idle(1);
    chk("R7 int_n low", {7'b0, int_n}, 8'h00);
    wr(3'd3, 8'h40); idle(1);
    chk("R7 aie off", {7'b0, int_n}, 8'h01);
    wr(3'd3, 8'h41); int_ctl = 1'b0; idle(2);
    chk("R7 int_ctl off", {7'b0, int_n}, 8'h01);
    int_ctl = 1'b1;
    wr(3'd4, 8'h01); idle(1);
    chk("R9 write 1 ignored", {7'b0, alarm_flag}, 8'h01);
    wr(3'd4, 8'h00); idle(1);
    chk("R9 write 0 clears", {7'b0, alarm_flag}, 8'h00);
    ts(2); idle(1);
    chk("R3 reloaded", {7'b0, alarm_flag}, 8'h00);
    ts(1);
    chk("R3 repeats", {7'b0, alarm_flag}, 8'h01);
    wr(3'd4, 8'h00);

    // R4/R5/R6 watchdog, reload 5, steer to reset
    wr(3'd3, 8'h00); wr(3'd0, 8'd5); wr(3'd3, 8'h60); idle(1);
    tf(4); rd(3'd0); idle(1);
    tf(4); idle(1);
    chk("R5 access reloads", {7'b0, alarm_flag}, 8'h00);
    tf(1);
    chk("R4 flag", {7'b0, alarm_flag}, 8'h01);
    idle(1);
    chk("R6 reset_n low", {7'b0, reset_n}, 8'h00);
    chk("R6 int_n high", {7'b0, int_n}, 8'h01);
    tf(7); idle(1);
    chk("R6 still low", {7'b0, reset_n}, 8'h00);
    tf(1); idle(1);
    chk("R6 pulse ends", {7'b0, reset_n}, 8'h01);
    wr(3'd4, 8'h00); tf(10); idle(1);
    chk("R4 stopped", {7'b0, alarm_flag}, 8'h00);

    // R6/R8 steered to interrupt
    wr(3'd3, 8'h00); wr(3'd3, 8'h69); idle(1);
    tf(5); idle(1);
    chk("R6 int_n pulse", {7'b0, int_n}, 8'h00);
    chk("R6 reset_n idle", {7'b0, reset_n}, 8'h01);
    wr(3'd4, 8'h00); wr(3'd3, 8'h68); idle(1);
    chk("R8 not cut", {7'b0, int_n}, 8'h00);
    tf(8); idle(1);
    chk("R8 pulse ends", {7'b0, int_n}, 8'h01);

    // R10 zero reload
    wr(3'd3, 8'h00); wr(3'd0, 8'd0); wr(3'd3, 8'h60); idle(1);
    tf(20); idle(1);
    chk("R10 no flag", {7'b0, alarm_flag}, 8'h00);
    chk("R10 no pulse", {7'b0, reset_n}, 8'h01);
    wr(3'd3, 8'h40); idle(1); ts(5); idle(1);
    chk("R10 alarm idle", {7'b0, alarm_flag}, 8'h00);

    $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule